// File: doc/BRIEF.md
# Three-Channel Reload Down-Counter Timer

This block is a memory-mapped timer with three independent down-counting channels. Each channel has a 32-bit counter, a 32-bit reload constant and a control register. A channel counts only while its bit in the shared start register is set. It decrements once per tick from a shared free-running prescaler. The channel's three-bit rate select in its control register picks the prescaler tap.

When a running channel's counter is zero and a tick arrives, the counter takes the reload constant instead of wrapping, and the channel's sticky underflow flag is set. Each channel drives a level interrupt, which is high while both the underflow flag and the channel's interrupt enable are set. Software clears the flag by writing 0 to it. Writing 1 to the flag leaves it unchanged.

The register port is a single-cycle write strobe with a combinational read. A shared output-control register, the start register and a read-only capture word for channel 2 complete the map.

Top module: `reload_timer3`

## Requirements
- R1: After reset, every channel's constant and counter read 0xFFFFFFFF. Every control register, the output-control register (byte 0x00) and the start register (byte 0x04) read 0, and all interrupts are low.
- R2: Channel c has its constant at byte 0x08+12c, its counter at 0x0C+12c and its control register at 0x10+12c. Constant and counter read back the last value written. In the output-control register only bit 0 is stored. In the start register, bit c runs channel c and reads back.
- R3: A running channel with rate select (control bits [2:0]) k in 0..4 decrements once every 4<<(2k) clock cycles: 4, 16, 64, 256 or 1024. Running it for exactly N such periods lowers the counter by exactly N.
- R4: Rate select codes 5, 6 and 7 deliver no ticks, so the counter of a running channel holds.
- R5: A channel whose start bit is 0 holds its counter.
- R6: When a tick arrives while the counter is 0, the counter loads the constant and the underflow flag (control bit 8) is set.
- R7: Interrupt c is high exactly when channel c's underflow flag and its enable (control bit 5) are both 1. The flag stays set until software clears it.
- R8: Writing 0 to control bit 8 clears the flag, and the interrupt is low from the next clock edge on. Writing 1 to bit 8 never sets it.
- R9: Control bits [7:0] take the written value under a mask. Channels 0 and 1 store bits [5:0], so writing 0xFFFF reads back 0x003F. Channel 2 stores bits [7:0], so it reads back 0x00FF, and its input-capture flag (bit 9) reads 0.
- R10: The capture word at byte 0x2C reads 0 and ignores writes. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 3 | Level interrupt per channel |

## Verification
The bench runs every prescaler code for an exact whole number of periods, so a divider tapped off by one bit or an off-by-one tick would shift the counter by a full period count. Underflow is driven from small counts and also from zero, which catches a counter that wraps to all ones instead of reloading. The flag tests write 1 to a clear flag and 0 to a set flag, and check the interrupt right after the clearing edge, which catches a flag that software can set or an interrupt that lags. Writes of all ones to each channel's control register and to the capture word catch wrong per-channel masks and a capture word that stores data.

// File: rtl/rt3_pkg.sv
package rt3_pkg;
   // Word indices of the shared registers
   localparam int W_OUTCTL  = 0;
   localparam int W_START   = 1;
   localparam int W_CH_BASE = 2;
   localparam int W_PER_CH  = 3;
   localparam int W_CAPTURE = 11;

   // Field positions in a channel control register
   localparam int B_ENABLE = 5;
   localparam int B_FLAG   = 8;
   localparam int B_ICF    = 9;

   // Write mask of a channel control register
   function automatic logic [15:0] ctl_mask(input int ch);
      return (ch == 2) ? 16'h03FF : 16'h013F;
   endfunction
endpackage

// File: rtl/rt3_prescaler.sv
module rt3_prescaler #(
   parameter int NCODES = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [NCODES-1:0] tick
);
   localparam int PS_W = 2 * NCODES;

   logic [PS_W-1:0] ps_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ps_q <= '0;
      else        ps_q <= ps_q + 1'b1;
   end

   // Tap k fires once every 4 << 2k cycles
   for (genvar k = 0; k < NCODES; k++) begin : g_tap
      assign tick[k] = &ps_q[2*k+1:0];
      if (k > 0) begin : g_nest
         // R3: a slower tap only fires together with every faster one
         p_taps_nested_r3: assert property (@(posedge clk) disable iff (!rst_n)
            tick[k] |-> tick[k-1]);
      end
   end
endmodule

// File: rtl/rt3_channel.sv
module rt3_channel #(
   parameter int          CNT_W   = 32,
   parameter int          NCODES  = 5,
   parameter logic [15:0] WMASK   = 16'h013F,
   parameter bit          HAS_ICF = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [NCODES-1:0] tick_vec,
   input  logic              wr_cor,
   input  logic              wr_cnt,
   input  logic              wr_ctl,
   input  logic [31:0]       wdata,
   output logic [CNT_W-1:0]  cor_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [15:0]       ctl_q,
   output logic              irq
);
   import rt3_pkg::*;

   logic [7:0] lo_q;
   logic       flag_q;
   logic       icf;
   logic [7:0] tv;
   logic       tick;
   logic       step;
   logic       uflow;

   // Codes beyond the prescaler taps select a zero tick
   assign tv    = 8'(tick_vec);
   assign tick  = tv[lo_q[2:0]];
   assign step  = run & tick;
   assign uflow = step & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
         cor_q <= '1;
      end else begin
         if (wr_cor) cor_q <= wdata[CNT_W-1:0];
         if (wr_cnt)     cnt_q <= wdata[CNT_W-1:0];
         else if (uflow) cnt_q <= cor_q;
         else if (step)  cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctl) lo_q <= wdata[7:0] & WMASK[7:0];
         if (uflow)                           flag_q <= 1'b1;
         else if (wr_ctl && !wdata[B_FLAG])   flag_q <= 1'b0;
      end
   end

   if (HAS_ICF) begin : g_icf
      logic icf_q;
      // Capture is out of scope: only software clear acts on this flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      icf_q <= 1'b0;
         else if (wr_ctl) icf_q <= icf_q & wdata[B_ICF];
      end
      assign icf = icf_q;
   end else begin : g_no_icf
      assign icf = 1'b0;
   end

   assign ctl_q = {6'b0, icf, flag_q, lo_q};
   assign irq   = flag_q & lo_q[B_ENABLE];

   // R6: underflow reloads from the constant and sets the flag
   p_reload_on_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt_q == '0 && !wr_cnt && !wr_cor) |=> (cnt_q == $past(cor_q) && ctl_q[B_FLAG]));
   // R5: a stopped channel holds its count
   p_hold_when_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt) |=> $stable(cnt_q));
   // R4: codes without a prescaler tap hold the count
   p_hold_on_idle_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(lo_q[2:0]) >= NCODES && !wr_cnt) |=> $stable(cnt_q));
   // R8: software never sets the flag
   p_no_soft_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[B_FLAG] && !(run && tick && cnt_q == '0)) |=> !ctl_q[B_FLAG]);
   // R8: clearing the flag drops the interrupt at the next edge
   p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !wdata[B_FLAG] && !(run && tick && cnt_q == '0)) |=> !irq);
endmodule

// File: rtl/reload_timer3.sv
module reload_timer3 #(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 32,
   parameter int NCODES = 5,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   import rt3_pkg::*;

   localparam int WORD_W = ADDR_W - 2;

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("reload_timer3: NUM_CH must be 1 to 3");
   end
   if (CNT_W < 16 || CNT_W > 32) begin : g_bad_w
      $error("reload_timer3: CNT_W must be 16 to 32");
   end
   if (NCODES < 1 || NCODES > 8) begin : g_bad_codes
      $error("reload_timer3: NCODES must be 1 to 8");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("reload_timer3: ADDR_W must cover the map");
   end

   logic [WORD_W-1:0] word;
   logic              aligned;
   logic              outctl_q;
   logic [NUM_CH-1:0] start_q;
   logic [NCODES-1:0] tick;
   logic [CNT_W-1:0]  cor_a [NUM_CH];
   logic [CNT_W-1:0]  cnt_a [NUM_CH];
   logic [15:0]       ctl_a [NUM_CH];

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outctl_q <= 1'b0;
         start_q  <= '0;
      end else if (bus_wr && aligned) begin
         if (int'(word) == W_OUTCTL) outctl_q <= bus_wdata[0];
         if (int'(word) == W_START)  start_q  <= bus_wdata[NUM_CH-1:0];
      end
   end

   rt3_prescaler #(.NCODES(NCODES)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int BASE = W_CH_BASE + W_PER_CH * c;
      logic sel_cor, sel_cnt, sel_ctl;
      assign sel_cor = bus_wr && aligned && int'(word) == BASE;
      assign sel_cnt = bus_wr && aligned && int'(word) == BASE + 1;
      assign sel_ctl = bus_wr && aligned && int'(word) == BASE + 2;

      rt3_channel #(
         .CNT_W   (CNT_W),
         .NCODES  (NCODES),
         .WMASK   (ctl_mask(c)),
         .HAS_ICF (c == 2)
      ) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (start_q[c]),
         .tick_vec (tick),
         .wr_cor   (sel_cor),
         .wr_cnt   (sel_cnt),
         .wr_ctl   (sel_ctl),
         .wdata    (bus_wdata),
         .cor_q    (cor_a[c]),
         .cnt_q    (cnt_a[c]),
         .ctl_q    (ctl_a[c]),
         .irq      (irq[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (int'(word) == W_OUTCTL) bus_rdata = {31'b0, outctl_q};
         if (int'(word) == W_START)  bus_rdata = 32'(start_q);
         for (int c = 0; c < NUM_CH; c++) begin
            if (int'(word) == W_CH_BASE + W_PER_CH * c)     bus_rdata = 32'(cor_a[c]);
            if (int'(word) == W_CH_BASE + W_PER_CH * c + 1) bus_rdata = 32'(cnt_a[c]);
            if (int'(word) == W_CH_BASE + W_PER_CH * c + 2) bus_rdata = 32'(ctl_a[c]);
         end
      end
   end

   // R10: the capture word always reads zero
   p_capture_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(4 * W_CAPTURE)) |-> (bus_rdata == '0));
   // R2: the start register only changes through a write
   p_start_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && aligned && int'(word) == W_START) |=> $stable(start_q));
endmodule

// File: tb/sim_reload_timer3.sv
module sim_reload_timer3;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   reload_timer3 u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   function automatic logic [5:0] a_cor(input int c); return 6'(8 + 12*c);  endfunction
   function automatic logic [5:0] a_cnt(input int c); return 6'(12 + 12*c); endfunction
   function automatic logic [5:0] a_ctl(input int c); return 6'(16 + 12*c); endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // Run a channel for exactly 'edges' clock edges
   task automatic run_for(input int c, input int edges);
      wr(6'h04, 32'(1 << c));
      repeat (edges - 1) @(posedge clk);
      wr(6'h04, 32'h0);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int c = 0; c < 3; c++) begin
         rd(a_cor(c), d); chk("R1 constant reset", d, 32'hFFFF_FFFF);
         rd(a_cnt(c), d); chk("R1 counter reset", d, 32'hFFFF_FFFF);
         rd(a_ctl(c), d); chk("R1 control reset", d, 32'h0);
      end
      rd(6'h00, d); chk("R1 output control reset", d, 32'h0);
      rd(6'h04, d); chk("R1 start reset", d, 32'h0);
      chk("R1 irq reset", 32'(irq), 32'h0);
   endtask

   task automatic t_regs;
      logic [31:0] d;
      wr(6'h00, 32'hFFFF_FFFF);
      rd(6'h00, d); chk("R2 output control bit0 only", d, 32'h1);
      wr(6'h04, 32'h0000_0005);
      rd(6'h04, d); chk("R2 start readback", d, 32'h5);
      wr(6'h04, 32'h0);
      wr(a_cor(1), 32'h1234_5678);
      rd(a_cor(1), d); chk("R2 constant readback", d, 32'h1234_5678);
      wr(a_cnt(2), 32'hCAFE_0042);
      rd(a_cnt(2), d); chk("R2 counter readback", d, 32'hCAFE_0042);
   endtask

   task automatic t_mask;
      logic [31:0] d;
      wr(a_ctl(0), 32'hFFFF); rd(a_ctl(0), d); chk("R9 ch0 mask", d, 32'h003F);
      wr(a_ctl(1), 32'hFFFF); rd(a_ctl(1), d); chk("R9 ch1 mask", d, 32'h003F);
      wr(a_ctl(2), 32'hFFFF); rd(a_ctl(2), d); chk("R9 ch2 mask, R8 no soft set", d, 32'h00FF);
      for (int c = 0; c < 3; c++) wr(a_ctl(c), 32'h0);
   endtask

   task automatic t_prescale;
      logic [31:0] d;
      for (int k = 0; k < 5; k++) begin
         wr(a_ctl(0), 32'(k));
         wr(a_cnt(0), 32'd1000);
         run_for(0, 3 * (4 << (2*k)));
         rd(a_cnt(0), d); chk($sformatf("R3 code %0d three periods", k), d, 32'd997);
      end
   endtask

   task automatic t_idle_codes;
      logic [31:0] d;
      for (int k = 5; k < 8; k++) begin
         wr(a_ctl(1), 32'(k));
         wr(a_cnt(1), 32'd500);
         run_for(1, 64);
         rd(a_cnt(1), d); chk($sformatf("R4 code %0d holds", k), d, 32'd500);
      end
   endtask

   task automatic t_stopped;
      logic [31:0] d;
      wr(a_ctl(0), 32'h0);
      wr(a_cnt(0), 32'd77);
      repeat (100) @(posedge clk);
      rd(a_cnt(0), d); chk("R5 stopped holds", d, 32'd77);
   endtask

   task automatic t_underflow;
      logic [31:0] d;
      wr(a_ctl(1), 32'h0);
      wr(a_cor(1), 32'd5);
      wr(a_cnt(1), 32'd2);
      run_for(1, 12);
      rd(a_cnt(1), d); chk("R6 reload after underflow", d, 32'd5);
      rd(a_ctl(1), d); chk("R6 flag set", d, 32'h0100);
      chk("R7 irq gated by enable", 32'(irq), 32'h0);
      wr(a_ctl(1), 32'h0120);
      chk("R7 irq with flag and enable", 32'(irq), 32'h2);
      rd(a_ctl(1), d); chk("R8 writing 1 keeps flag", d, 32'h0120);
      repeat (20) @(posedge clk);
      chk("R7 flag sticky", 32'(irq), 32'h2);
      wr(a_ctl(1), 32'h0020);
      chk("R8 irq low after clear", 32'(irq), 32'h0);
      rd(a_ctl(1), d); chk("R8 flag cleared", d, 32'h0020);
      wr(a_cor(1), 32'd9);
      wr(a_cnt(1), 32'd0);
      run_for(1, 4);
      rd(a_cnt(1), d); chk("R6 reload from zero", d, 32'd9);
      chk("R7 irq after second underflow", 32'(irq), 32'h2);
      wr(a_ctl(1), 32'h0);
   endtask

   task automatic t_capture;
      logic [31:0] d;
      wr(a_ctl(2), 32'h0003);
      rd(6'h2C, d); chk("R10 capture reads 0", d, 32'h0);
      wr(6'h2C, 32'hFFFF_FFFF);
      rd(6'h2C, d); chk("R10 capture ignores write", d, 32'h0);
      rd(a_ctl(2), d); chk("R10 capture write leaves ch2 control", d, 32'h0003);
      rd(6'h30, d); chk("R10 unmapped reads 0", d, 32'h0);
      rd(6'h09, d); chk("R10 misaligned reads 0", d, 32'h0);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog R1-bench hung actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_regs();
      t_mask();
      t_prescale();
      t_idle_codes();
      t_stopped();
      t_underflow();
      t_capture();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule